// File: doc/BRIEF.md
# Monitor Detect Interrupt Controller

This block holds the status, interrupt and identification registers of a display link transmitter. It watches two attach-detect inputs, a hot-plug line and a receiver-sense line, through a synchronizer. It records a level change on whichever of the two a configuration bit selects. The event shows up in an active-low status bit that software clears by writing one to it.

A three-bit field picks what drives a single attach-status output pin. The choices are a constant high, the event bit, or either live detect level. A fixed set of read-only bytes identifies the block and its frequency range.

Access is a plain synchronous register port: an address, write data and write enable, with read data returned combinationally for the presented address. The serial transport that would carry these accesses sits outside the block.

Top module: `mdi_monitor_top`

## Requirements
- R1: Read-only identity bytes read as: address 0x0 = 0x01, 0x1 = 0x00, 0x2 = 0x06, 0x3 = 0x00, 0x4 = 0x00, 0x5 = 0x19, 0x6 = 0x64; writes to them have no effect.
- R2: After reset the configuration register (address 0x8) reads 0x00, the status register (address 0x9) reads 0x01 and `attachPin` is high.
- R3: The status register has the event bit at bit 0, which reads 1 when no change is pending. Bit 0 reads 0 from the third rising clock edge after the selected detect input changes level. A change on the unselected input never alters bit 0.
- R4: Writing the status register with bit 0 set clears a pending event, and bit 0 reads 1 after that write edge. Writing it with bit 0 clear has no effect.
- R5: If a new change on the selected input is detected in the same cycle as a clearing write, the event stays pending.
- R6: The configuration register holds the source select at bit 0 (0 = receiver sense, 1 = hot-plug) and the pin select at bits 3:1. It reads back as written. Pin select 000 drives `attachPin` high, 001 drives the event bit, 010 drives live receiver sense and 011 drives live hot-plug.
- R7: Pin select codes 100 to 111 drive `attachPin` high.
- R8: Status bit 1 shows the hot-plug level and bit 2 the receiver-sense level, each visible from the second rising edge after the input changes.
- R9: Changing the source select does not by itself raise an event, even when the two inputs differ.
- R10: Unmapped addresses read 0x00, and writes to them change no readable state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register address |
| wrData | input | DATA_W | Write data |
| wrEn | input | 1 | Write strobe, taken on the rising edge |
| rdData | output | DATA_W | Read data for `regAddr`, combinational |
| hotPlugIn | input | 1 | Asynchronous hot-plug detect level |
| rxSenseIn | input | 1 | Asynchronous receiver-sense level |
| attachPin | output | 1 | Selected attach-status output |

## Verification
Read data and `attachPin` follow the register state without delay. A register write is visible from the edge that takes it. A detect level reaches the live status bits two edges after it changes, and it reaches the event bit three edges after it changes. The bench drives inputs on falling edges and counts rising edges explicitly before sampling at the following falling edge. It checks both the cycle before and the cycle of each expected transition, so an extra or missing register stage is caught. The coincident change-and-clear case is lined up so that the write lands on the exact edge where the change is detected.

// File: rtl/mdi_monitor_pkg.sv
package mdi_monitor_pkg;

  localparam logic [3:0] ADDR_VEN_LO = 4'h0;
  localparam logic [3:0] ADDR_VEN_HI = 4'h1;
  localparam logic [3:0] ADDR_DEV_LO = 4'h2;
  localparam logic [3:0] ADDR_DEV_HI = 4'h3;
  localparam logic [3:0] ADDR_REV    = 4'h4;
  localparam logic [3:0] ADDR_FLO    = 4'h5;
  localparam logic [3:0] ADDR_FHI    = 4'h6;
  localparam logic [3:0] ADDR_CFG    = 4'h8;
  localparam logic [3:0] ADDR_STAT   = 4'h9;

  localparam logic [2:0] PIN_HIGH  = 3'b000;
  localparam logic [2:0] PIN_EVENT = 3'b001;
  localparam logic [2:0] PIN_RSENS = 3'b010;
  localparam logic [2:0] PIN_HPLUG = 3'b011;

  // Strobes and settings from control to datapath
  typedef struct packed {
    logic       clrEvent;
    logic       srcSel;   // 0: receiver sense, 1: hot-plug
    logic [2:0] pinSel;
  } mdiCtrl_t;

  // Status returned from datapath to control
  typedef struct packed {
    logic eventBit;   // active low: 0 means change pending
    logic hotPlug;
    logic rxSense;
  } mdiStat_t;

endpackage

// File: rtl/mdi_monitor_datapath.sv
module mdi_monitor_datapath
  import mdi_monitor_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     hotPlugIn,
  input  logic     rxSenseIn,
  input  mdiCtrl_t ctrl,
  output mdiStat_t stat,
  output logic     evtChange,
  output logic     attachPin
);

  localparam int NUM_SRC = 2;  // bit 0: hot-plug, bit 1: receiver sense

  logic [NUM_SRC-1:0] rawIn;
  logic [NUM_SRC-1:0] syncQ [SYNC_STAGES];
  logic [NUM_SRC-1:0] liveLvl;
  logic [NUM_SRC-1:0] prevLvl;
  logic [NUM_SRC-1:0] edgeSeen;
  logic               pendingQ;
  logic               eventBit;

  assign rawIn = {rxSenseIn, hotPlugIn};

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[g] <= '0;
          else       syncQ[g] <= rawIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[g] <= '0;
          else       syncQ[g] <= syncQ[g-1];
        end
      end
    end
  endgenerate

  assign liveLvl = syncQ[SYNC_STAGES-1];

  // Both sources keep their own baseline, so a source switch sees no step
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= '0;
    else       prevLvl <= liveLvl;
  end

  assign edgeSeen  = liveLvl ^ prevLvl;
  assign evtChange = ctrl.srcSel ? edgeSeen[0] : edgeSeen[1];

  // A new change outranks a clearing write in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendingQ <= 1'b0;
    else       pendingQ <= (pendingQ & ~ctrl.clrEvent) | evtChange;
  end

  assign eventBit = ~pendingQ;

  always_comb begin
    unique case (ctrl.pinSel)
      PIN_HIGH:  attachPin = 1'b1;
      PIN_EVENT: attachPin = eventBit;
      PIN_RSENS: attachPin = liveLvl[1];
      PIN_HPLUG: attachPin = liveLvl[0];
      default:   attachPin = 1'b1;
    endcase
  end

  assign stat.eventBit = eventBit;
  assign stat.hotPlug  = liveLvl[0];
  assign stat.rxSense  = liveLvl[1];

endmodule

// File: rtl/mdi_monitor_control.sv
module mdi_monitor_control
  import mdi_monitor_pkg::*;
#(
  parameter int          ADDR_W  = 4,
  parameter int          DATA_W  = 8,
  parameter logic [15:0] VEN_ID  = 16'h0001,
  parameter logic [15:0] DEV_ID  = 16'h0006,
  parameter logic [7:0]  REV_ID  = 8'h00,
  parameter logic [7:0]  FREQ_LO = 8'h19,
  parameter logic [7:0]  FREQ_HI = 8'h64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  mdiStat_t          stat,
  output mdiCtrl_t          ctrl,
  output logic [DATA_W-1:0] rdData
);

  localparam int CFG_W = 4;

  logic             srcSelQ;
  logic [2:0]       pinSelQ;
  logic             cfgHit;
  logic             statHit;
  logic [DATA_W-1:0] cfgWord;
  logic [DATA_W-1:0] statWord;
  logic             unusedWrBits;

  assign cfgHit  = (regAddr == ADDR_W'(ADDR_CFG));
  assign statHit = (regAddr == ADDR_W'(ADDR_STAT));
  assign unusedWrBits = ^wrData[DATA_W-1:CFG_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcSelQ <= 1'b0;
      pinSelQ <= PIN_HIGH;
    end else if (wrEn && cfgHit) begin
      srcSelQ <= wrData[0];
      pinSelQ <= wrData[3:1];
    end
  end

  assign ctrl.clrEvent = wrEn && statHit && wrData[0];
  assign ctrl.srcSel   = srcSelQ;
  assign ctrl.pinSel   = pinSelQ;

  assign cfgWord  = DATA_W'({pinSelQ, srcSelQ});
  assign statWord = DATA_W'({stat.rxSense, stat.hotPlug, stat.eventBit});

  always_comb begin
    rdData = '0;
    if      (regAddr == ADDR_W'(ADDR_VEN_LO)) rdData = DATA_W'(VEN_ID[7:0]);
    else if (regAddr == ADDR_W'(ADDR_VEN_HI)) rdData = DATA_W'(VEN_ID[15:8]);
    else if (regAddr == ADDR_W'(ADDR_DEV_LO)) rdData = DATA_W'(DEV_ID[7:0]);
    else if (regAddr == ADDR_W'(ADDR_DEV_HI)) rdData = DATA_W'(DEV_ID[15:8]);
    else if (regAddr == ADDR_W'(ADDR_REV))    rdData = DATA_W'(REV_ID);
    else if (regAddr == ADDR_W'(ADDR_FLO))    rdData = DATA_W'(FREQ_LO);
    else if (regAddr == ADDR_W'(ADDR_FHI))    rdData = DATA_W'(FREQ_HI);
    else if (cfgHit)                          rdData = cfgWord;
    else if (statHit)                         rdData = statWord;
  end

endmodule

// File: rtl/mdi_monitor_top.sv
module mdi_monitor_top
  import mdi_monitor_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              hotPlugIn,
  input  logic              rxSenseIn,
  output logic              attachPin
);

  mdiCtrl_t ctrlBus;
  mdiStat_t statBus;
  logic     evtChange;

  mdi_monitor_control #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uControl (
    .clk    (clk),
    .rstN   (rstN),
    .regAddr(regAddr),
    .wrData (wrData),
    .wrEn   (wrEn),
    .stat   (statBus),
    .ctrl   (ctrlBus),
    .rdData (rdData)
  );

  mdi_monitor_datapath #(
    .SYNC_STAGES(SYNC_STAGES)
  ) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .hotPlugIn(hotPlugIn),
    .rxSenseIn(rxSenseIn),
    .ctrl     (ctrlBus),
    .stat     (statBus),
    .evtChange(evtChange),
    .attachPin(attachPin)
  );

endmodule

// File: rtl/mdi_monitor_checker.sv
module mdi_monitor_checker (
  input logic       clk,
  input logic       rstN,
  input logic       clrEvent,
  input logic       evtChange,
  input logic       eventBit,
  input logic [2:0] pinSel,
  input logic       hotPlug,
  input logic       rxSense,
  input logic       attachPin
);

  p_pending_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    evtChange |=> !eventBit);

  p_quiet_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!evtChange && !clrEvent) |=> (eventBit == $past(eventBit)));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (clrEvent && !evtChange) |=> eventBit);

  p_change_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
    (clrEvent && evtChange) |=> !eventBit);

  p_pin_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pinSel == 3'b000) |-> attachPin);

  p_pin_event_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pinSel == 3'b001) |-> (attachPin == eventBit));

  p_pin_rsense_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pinSel == 3'b010) |-> (attachPin == rxSense));

  p_pin_hplug_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pinSel == 3'b011) |-> (attachPin == hotPlug));

  p_pin_reserved_r7: assert property (@(posedge clk) disable iff (!rstN)
    pinSel[2] |-> attachPin);

endmodule

bind mdi_monitor_top mdi_monitor_checker uChecker (
  .clk      (clk),
  .rstN     (rstN),
  .clrEvent (ctrlBus.clrEvent),
  .evtChange(evtChange),
  .eventBit (statBus.eventBit),
  .pinSel   (ctrlBus.pinSel),
  .hotPlug  (statBus.hotPlug),
  .rxSense  (statBus.rxSense),
  .attachPin(attachPin)
);

// File: tb/tb_mdi_monitor_top.sv
module tb_mdi_monitor_top;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_VEC    = 10;

  // {address, write value, expected read}
  localparam logic [19:0] VEC [NUM_VEC] = '{
    {4'h0, 8'hFF, 8'h01}, {4'h1, 8'hFF, 8'h00}, {4'h2, 8'hFF, 8'h06},
    {4'h3, 8'hFF, 8'h00}, {4'h4, 8'hFF, 8'h00}, {4'h5, 8'hFF, 8'h19},
    {4'h6, 8'hFF, 8'h64}, {4'h7, 8'hFF, 8'h00}, {4'hA, 8'hFF, 8'h00},
    {4'hF, 8'hFF, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] wrData = '0;
  logic       wrEn = 1'b0;
  logic [7:0] rdData;
  logic       hotPlugIn = 1'b0;
  logic       rxSenseIn = 1'b0;
  logic       attachPin;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdi_monitor_top dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrData(wrData), .wrEn(wrEn),
    .rdData(rdData), .hotPlugIn(hotPlugIn), .rxSenseIn(rxSenseIn),
    .attachPin(attachPin)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [3:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R2 reset state
    readReg(4'h8, r); check("R2 cfg", r, 8'h00);
    readReg(4'h9, r); check("R2 status", r, 8'h01);
    check("R2 pin", {7'd0, attachPin}, 8'h01);

    // R1 / R10 table: write then read back
    for (int i = 0; i < NUM_VEC; i++) begin
      writeReg(VEC[i][19:16], VEC[i][15:8]);
      readReg(VEC[i][19:16], r);
      check((VEC[i][19:16] > 4'h6) ? "R10 unmapped" : "R1 id", r, VEC[i][7:0]);
    end
    readReg(4'h8, r); check("R10 cfg untouched", r, 8'h00);
    readReg(4'h9, r); check("R10 status untouched", r, 8'h01);

    // R8 / R3: hot-plug change while receiver sense is selected
    @(negedge clk); hotPlugIn = 1'b1;
    edges(1); readReg(4'h9, r); check("R8 hp not yet", r, 8'h01);
    edges(1); readReg(4'h9, r); check("R8 hp live", r, 8'h03);
    edges(3); readReg(4'h9, r); check("R3 unselected ignored", r, 8'h03);

    // R3: selected receiver-sense change
    rxSenseIn = 1'b1;
    edges(2); readReg(4'h9, r); check("R3 before third edge", r, 8'h07);
    edges(1); readReg(4'h9, r); check("R3 event at third edge", r, 8'h06);

    // R4 clear behaviour
    writeReg(4'h9, 8'hFE); readReg(4'h9, r); check("R4 zero write no effect", r, 8'h06);
    writeReg(4'h9, 8'h01); readReg(4'h9, r); check("R4 cleared", r, 8'h07);

    // R6 pin select
    writeReg(4'h8, 8'h02); check("R6 pin event idle", {7'd0, attachPin}, 8'h01);
    rxSenseIn = 1'b0;
    edges(3); check("R6 pin event pending", {7'd0, attachPin}, 8'h00);
    writeReg(4'h8, 8'h04); check("R6 pin rsense", {7'd0, attachPin}, 8'h00);
    writeReg(4'h8, 8'h06); check("R6 pin hplug", {7'd0, attachPin}, 8'h01);
    readReg(4'h8, r); check("R6 cfg readback", r, 8'h06);
    writeReg(4'h8, 8'h00); check("R6 pin high", {7'd0, attachPin}, 8'h01);

    // R7 reserved codes
    for (int c = 4; c < 8; c++) begin
      writeReg(4'h8, 8'(c << 1));
      check("R7 reserved high", {7'd0, attachPin}, 8'h01);
    end
    writeReg(4'h8, 8'h00);

    // R5: event already pending, new change coincides with clear
    readReg(4'h9, r); check("R5 precondition", r, 8'h02);
    rxSenseIn = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    regAddr = 4'h9; wrData = 8'h01; wrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    readReg(4'h9, r); check("R5 change beats clear", r, 8'h06);
    writeReg(4'h9, 8'h01); readReg(4'h9, r); check("R5 later clear", r, 8'h07);

    // R9: source switch with differing levels
    hotPlugIn = 1'b0;
    edges(4); readReg(4'h9, r); check("R9 hp low rs high", r, 8'h05);
    writeReg(4'h8, 8'h01);
    edges(4); readReg(4'h9, r); check("R9 no spurious event", r, 8'h05);

    // R3 with hot-plug selected; receiver sense ignored
    rxSenseIn = 1'b0;
    edges(4); readReg(4'h9, r); check("R3 rs ignored when hp selected", r, 8'h01);
    hotPlugIn = 1'b1;
    edges(2); readReg(4'h9, r); check("R3 hp before third edge", r, 8'h03);
    edges(1); readReg(4'h9, r); check("R3 hp event", r, 8'h02);

    // R2 reset again clears state
    rstN = 1'b0; #1;
    readReg(4'h8, r); check("R2 cfg after reset", r, 8'h00);
    readReg(4'h9, r); check("R2 status after reset", r, 8'h01);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule